// File: doc/BRIEF.md
# Flash Write-Completion Poller

This block sits on the host side of a parallel NOR flash. It finds out when a program or erase that is already running inside the flash has finished. Sending the command sequence that starts the operation is not part of this block. Once that sequence has been written, the host pulses `start` and supplies four things: the word address to watch, the word it expects to find there when the operation is over, a status method, and whether the operation is a program or an erase. The block then reads that address again and again through a read port that carries one pulsed request and one response at a time. It judges each returned word with the chosen status method.

There are two status methods. In the data-complement method, bit 7 reads as the inverse of the expected bit 7 while the flash is busy. In the toggle method, bit 6 flips on every read while the flash is busy. A read can land in the same moment the flash finishes, and then a status bit alone can mislead. For this reason a word that looks finished is accepted only after two more reads of the same address both return exactly the expected word. If either of those reads differs, polling simply goes on. The block ends each session with a one-cycle `done` pulse. If the session runs past a cycle budget, it ends with a one-cycle `error` pulse instead. There is one budget for program operations and a separate one for erase operations.

Top module: `flash_done_poller`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `busy`, `rd_req`, `done` and `error` are all low.
- R2: A `start` seen while idle raises `busy` and `rd_req` in the cycle after that clock edge. Every read request of the session carries the address captured with `start` on `rd_addr`.
- R3: With `mode_toggle` = 0 (data-complement method), a response whose bit 7 equals bit 7 of the expected word marks the location as apparently finished.
- R4: With `mode_toggle` = 1 (toggle method), a response whose bit 6 equals bit 6 of the response just before it marks the location as apparently finished. The first response of a session never does, because it has no predecessor.
- R5: After an apparent finish, exactly two more reads are issued. If both return the full expected word, the session completes. If either differs, the block goes back to status polling with no result, and reads continue.
- R6: `done` is a one-cycle pulse. It is high in the cycle after the clock edge that sampled the last confirming response, and `busy` is low in that same cycle.
- R7: If no completion has occurred, `error` pulses for one cycle exactly PROG_CYCLES cycles after the start edge when `op_erase` = 0, or ERASE_CYCLES cycles after it when `op_erase` = 1. After that, no further reads are issued.
- R8: A `start` that arrives while `busy` is high is ignored. The address and the expected word of the running session do not change.
- R9: At most one read is outstanding. No new `rd_req` is raised until the previous one has been answered by `rd_ack`.
- R10: `done` and `error` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a polling session (ignored while busy) |
| mode_toggle | input | 1 | 0: data-complement method on bit 7, 1: toggle method on bit 6 |
| op_erase | input | 1 | 0: use program timeout, 1: use erase timeout |
| addr | input | AW | Word address to poll |
| exp_data | input | DW | Word expected once the operation is over |
| rd_req | output | 1 | One-cycle read request pulse |
| rd_addr | output | AW | Address for the read request |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | DW | Read response word |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle timeout pulse |

## Verification
The first read request is due in the cycle right after the start edge. Every later request is due in the cycle right after the edge that sampled the previous response. `done` is due one cycle after the edge that took the final confirming response. `error` is due exactly one timeout budget after the start edge. The bench keeps a free-running edge counter and timestamps each response it drives. It also records the counter value at the start edge, so that each result is compared against the cycle the requirements name rather than merely being seen at some point. The number of reads a session must take is predicted by a bench model of the polling rules, applied to the response sequence the bench itself generates.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;
  typedef enum logic {ST_IDLE, ST_WAIT} fpoll_state_t;
  typedef enum logic {PH_SEEK, PH_CONFIRM} fpoll_phase_t;
endpackage

// File: rtl/fpoll_timer.sv
module fpoll_timer #(
  parameter int PROG_CYCLES  = 1250,
  parameter int ERASE_CYCLES = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic sel_erase,
  output logic expired
);
  localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last_cnt;

  assign last_cnt = sel_erase ? CW'(ERASE_CYCLES - 1) : CW'(PROG_CYCLES - 1);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (run)     cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == last_cnt);
endmodule

// File: rtl/fpoll_judge.sv
module fpoll_judge #(
  parameter int DW       = 16,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic          mode_toggle,
  input  logic [DW-1:0] rd_word,
  input  logic [DW-1:0] exp_word,
  input  logic          prev_tog,
  input  logic          have_prev,
  output logic          status_hit,
  output logic          word_match
);
  always_comb begin
    if (mode_toggle) status_hit = have_prev && (rd_word[TOG_BIT] == prev_tog);
    else             status_hit = (rd_word[POLL_BIT] == exp_word[POLL_BIT]);
    word_match = (rd_word == exp_word);
  end
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
  parameter int AW            = 22,
  parameter int DW            = 16,
  parameter int PROG_CYCLES   = 1250,
  parameter int ERASE_CYCLES  = 20000,
  parameter int POLL_BIT      = 7,
  parameter int TOG_BIT       = 6,
  parameter int CONFIRM_READS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mode_toggle,
  input  logic          op_erase,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] exp_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done,
  output logic          error
);
  import fpoll_pkg::*;

  localparam int CCW = $clog2(CONFIRM_READS + 1);

  fpoll_state_t  state;
  fpoll_phase_t  phase;
  logic [DW-1:0] exp_q;
  logic          tog_q;
  logic          erase_q;
  logic          prev_tog;
  logic          have_prev;
  logic [CCW-1:0] ccnt;
  logic          accept;
  logic          expired;
  logic          status_hit;
  logic          word_match;

  assign accept = (state == ST_IDLE) && start;

  fpoll_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept),
    .run      (state == ST_WAIT),
    .sel_erase(erase_q),
    .expired  (expired)
  );

  fpoll_judge #(
    .DW      (DW),
    .POLL_BIT(POLL_BIT),
    .TOG_BIT (TOG_BIT)
  ) u_judge (
    .mode_toggle(tog_q),
    .rd_word    (rd_data),
    .exp_word   (exp_q),
    .prev_tog   (prev_tog),
    .have_prev  (have_prev),
    .status_hit (status_hit),
    .word_match (word_match)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      phase     <= PH_SEEK;
      rd_req    <= 1'b0;
      rd_addr   <= '0;
      exp_q     <= '0;
      tog_q     <= 1'b0;
      erase_q   <= 1'b0;
      prev_tog  <= 1'b0;
      have_prev <= 1'b0;
      ccnt      <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      rd_req <= 1'b0;
      done   <= 1'b0;
      error  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            rd_addr   <= addr;
            exp_q     <= exp_data;
            tog_q     <= mode_toggle;
            erase_q   <= op_erase;
            have_prev <= 1'b0;
            phase     <= PH_SEEK;
            ccnt      <= '0;
            rd_req    <= 1'b1;
            busy      <= 1'b1;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (expired) begin
            error <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else if (rd_ack) begin
            prev_tog  <= rd_data[TOG_BIT];
            have_prev <= 1'b1;
            if (phase == PH_SEEK) begin
              if (status_hit) begin
                phase <= PH_CONFIRM;
                ccnt  <= '0;
              end
              rd_req <= 1'b1;
            end else if (!word_match) begin
              phase  <= PH_SEEK;
              rd_req <= 1'b1;
            end else if (ccnt == CCW'(CONFIRM_READS - 1)) begin
              done  <= 1'b1;
              busy  <= 1'b0;
              phase <= PH_SEEK;
              state <= ST_IDLE;
            end else begin
              ccnt   <= ccnt + 1'b1;
              rd_req <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpoll_checker.sv
module fpoll_checker #(
  parameter int PROG_CYCLES  = 1250,
  parameter int ERASE_CYCLES = 20000
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic rd_req,
  input logic rd_ack,
  input logic busy,
  input logic done,
  input logic error
);
  localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;

  logic outst;
  int   bcnt;

  always_ff @(posedge clk) begin
    if (rst || done || error) outst <= 1'b0;
    else                      outst <= (outst || rd_req) && !rd_ack;
    if (rst || !busy) bcnt <= 0;
    else              bcnt <= bcnt + 1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !rd_req && !done && !error));

  a_r2_first_request: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !done && !error) |=> (rd_req && busy));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r7_error_pulse: assert property (@(posedge clk) disable iff (rst)
    error |=> !error);

  a_r7_bounded_session: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bcnt < MAXC));

  a_r9_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !outst);

  a_r10_exclusive_result: assert property (@(posedge clk) disable iff (rst)
    !(done && error));
endmodule

bind flash_done_poller fpoll_checker #(
  .PROG_CYCLES (PROG_CYCLES),
  .ERASE_CYCLES(ERASE_CYCLES)
) u_fpoll_checker (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .rd_req(rd_req),
  .rd_ack(rd_ack),
  .busy  (busy),
  .done  (done),
  .error (error)
);

// File: tb/flash_done_poller_bench.sv
module flash_done_poller_bench;
  localparam int AW = 22;
  localparam int DW = 16;
  localparam int PROG = 60;
  localparam int ERASE = 150;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          mode_toggle = 1'b0;
  logic          op_erase = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] exp_data = '0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_ack = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic          busy, done, error;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  logic [DW-1:0] seq [64];
  int idx, rd_cnt, addr_bad, resp_lat, pend, ack_cyc, first_req;
  logic [AW-1:0] want_addr;

  flash_done_poller #(
    .AW(AW), .DW(DW), .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE)
  ) u_flash_done_poller (
    .clk(clk), .rst(rst), .start(start), .mode_toggle(mode_toggle),
    .op_erase(op_erase), .addr(addr), .exp_data(exp_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .busy(busy), .done(done), .error(error)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // flash responder: answers each request after resp_lat cycles
  initial begin
    pend = 0;
    forever begin
      @(negedge clk);
      rd_ack = 1'b0;
      if (rd_req) begin
        pend = resp_lat;
        rd_cnt++;
        if (first_req < 0) first_req = cyc;
        if (rd_addr != want_addr) addr_bad++;
      end
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          rd_ack  = 1'b1;
          rd_data = seq[(idx > 63) ? 63 : idx];
          idx++;
          ack_cyc = cyc;
        end
      end
    end
  end

  // number of reads the polling rules need for the current sequence, 0 if never
  function automatic int model_reads(input bit tog, input logic [DW-1:0] e);
    bit conf = 0;
    bit have = 0;
    bit prev = 0;
    int c = 0;
    for (int i = 0; i < 64; i++) begin
      logic [DW-1:0] d = seq[i];
      if (!conf) begin
        if (tog ? (have && d[6] == prev) : (d[7] == e[7])) begin
          conf = 1; c = 0;
        end
      end else if (d != e) begin
        conf = 0;
      end else if (c == 1) begin
        return i + 1;
      end else begin
        c++;
      end
      prev = d[6]; have = 1;
    end
    return 0;
  endfunction

  task automatic build(input bit tog, input logic [DW-1:0] e, input int nbusy,
                       input bit race, input bit good);
    bit t0 = 1'($urandom);
    for (int i = 0; i < 64; i++) begin
      logic [DW-1:0] w = DW'($urandom);
      if (i < nbusy) begin
        if (tog) w[6] = t0 ^ 1'(i);
        else     w[7] = ~e[7];
        seq[i] = w;
      end else begin
        seq[i] = good ? e : (e ^ 16'h0001);
      end
    end
    if (race && !tog && nbusy >= 4) begin
      seq[1] = e ^ 16'h0001;
      seq[1][7] = e[7];
    end
  endtask

  task automatic run(input bit tog, input bit er, input logic [DW-1:0] e,
                     input int lat, input bit expect_to, input bit inject);
    int s, w, want;
    logic [AW-1:0] a = AW'($urandom);
    want = model_reads(tog, e);
    resp_lat = lat; idx = 0; rd_cnt = 0; addr_bad = 0; first_req = -1;
    want_addr = a;
    @(negedge clk);
    addr = a; exp_data = e; mode_toggle = tog; op_erase = er; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    s = cyc;
    chk(busy === 1'b1, "R2", "busy after start", longint'(busy), 1);
    chk(first_req == s, "R2", "first request cycle", first_req, s);
    w = 0;
    while (!(done === 1'b1) && !(error === 1'b1) && w < 5000) begin
      @(negedge clk);
      w++;
      if (inject && w == 3) begin
        start = 1'b1; addr = ~a; exp_data = ~e;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk(w < 5000, "R6", "session ended", w, 0);
    if (expect_to) begin
      chk(error === 1'b1 && done === 1'b0, "R7", "timeout error", longint'(error), 1);
      chk(cyc - s == (er ? ERASE : PROG), "R7", "timeout cycle", cyc - s, er ? ERASE : PROG);
    end else begin
      chk(done === 1'b1 && error === 1'b0, tog ? "R4" : "R3", "completion", longint'(done), 1);
      chk(cyc == ack_cyc + 1, "R6", "done timing", cyc, ack_cyc + 1);
      chk(rd_cnt == want, "R5", "read count", rd_cnt, want);
      chk(busy === 1'b0, "R6", "busy low with done", longint'(busy), 0);
    end
    chk(addr_bad == 0, inject ? "R8" : "R2", "request address", addr_bad, 0);
    @(negedge clk);
    chk(done === 1'b0 && error === 1'b0, "R6", "single-cycle result", longint'({done, error}), 0);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    nerr++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int dummy;
    dummy = $urandom(32'd1234);
    resp_lat = 1; want_addr = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !rd_req && !done && !error, "R1", "outputs in reset", longint'({busy, rd_req, done, error}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !rd_req && !done && !error, "R1", "outputs after reset", longint'({busy, rd_req, done, error}), 0);
    // R3: data-complement, already finished
    build(1'b0, 16'h00A5, 0, 1'b0, 1'b1); run(1'b0, 1'b0, 16'h00A5, 1, 1'b0, 1'b0);
    // R4: toggle, already finished: first read has no predecessor
    build(1'b1, 16'hFFFF, 0, 1'b0, 1'b1); run(1'b1, 1'b1, 16'hFFFF, 2, 1'b0, 1'b0);
    // R5: racy read whose status bit looks finished, confirmation fails
    build(1'b0, 16'h1234, 5, 1'b1, 1'b1); run(1'b0, 1'b0, 16'h1234, 1, 1'b0, 1'b0);
    // R8: start during a session is ignored
    build(1'b1, 16'h5A5A, 4, 1'b0, 1'b1); run(1'b1, 1'b0, 16'h5A5A, 2, 1'b0, 1'b1);
    // R7: program and erase timeouts
    build(1'b0, 16'h0F0F, 3, 1'b0, 1'b0); run(1'b0, 1'b0, 16'h0F0F, 2, 1'b1, 1'b0);
    build(1'b1, 16'hFFFF, 2, 1'b0, 1'b0); run(1'b1, 1'b1, 16'hFFFF, 1, 1'b1, 1'b0);
    // random sessions
    for (int k = 0; k < 24; k++) begin
      bit tg = 1'($urandom);
      logic [DW-1:0] ev = DW'($urandom);
      int nb = int'($urandom % 7);
      int lt = 1 + int'($urandom % 3);
      build(tg, ev, nb, 1'($urandom), 1'b1);
      run(tg, 1'($urandom), ev, lt, 1'b0, 1'b0);
    end
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule